// File: doc/BRIEF.md
# Cache Control and Region Attribute Unit

This block holds the control state of a processor's unified cache. It also tags each processor access with three attributes, taken from the 2 MB region of the address: cacheable, updateable and disruptive. A small register port writes and reads the control registers. Software does a masked update (new = (old AND mask) XOR toggle) by reading a register, computing the value, and writing it back.

The access side takes a valid strobe, a 26-bit address and a write flag. The top five address bits select one of 32 regions. Each of the three attribute maps holds one bit per region. The attribute outputs are combinational from the access address. They are gated by the valid strobe, and the cacheable flag is also gated by the cache enable. The flush output is a registered, single-cycle pulse. It fires in the cycle after either of two events: a write to the flush register, or a processor write into a disruptive region. If both events arrive in the same cycle they give one pulse. The unit drives a second control bit as a level to the memory controller. That bit asks for one address translation shared by user and supervisor modes.

Top module: `cache_ctl_unit`

## Requirements
- R1: A register-port write to select 1 gives `flush_pulse` high for exactly the next cycle. The written data has no effect on any register.
- R2: `cache_en` follows bit 0 of the control register (select 2). While it is 0, `acc_cacheable` is 0 for every address.
- R3: `shared_xlat` follows bit 1 of the control register (select 2).
- R4: With the cache enabled and `acc_valid` high, `acc_cacheable` equals bit n of the cacheable map (select 3). Here n = `acc_addr[25:21]`.
- R5: With `acc_valid` high, `acc_updateable` equals bit n of the updateable map (select 4).
- R6: With `acc_valid` high, `acc_disruptive` equals bit n of the disruptive map (select 5). A write access to such a region gives `flush_pulse` in the next cycle. A read access to it does not.
- R7: Reset leaves these values: control register 0, cacheable map 0xFC007FFF, updateable map 0x00007FFF, disruptive map 0xF0000000. `flush_pulse` is low.
- R8: A flush-register write and a disruptive write access in the same cycle give one pulse, one cycle long.
- R9: Control register bits 31..2 read back as 0 whatever was written to them.
- R10: A map write applies to accesses that start in the next cycle.
- R11: Selects 2 to 5 read back the stored values. Selects 0, 1, 6 and 7 read as 0.
- R12: While `acc_valid` is low, all three attribute flags are 0 and no access-triggered flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| acc_valid | input | 1 | Processor access valid |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 26 | Access byte address |
| cache_en | output | 1 | Cache enable level |
| shared_xlat | output | 1 | Shared user/supervisor translation level |
| flush_pulse | output | 1 | One-cycle cache flush request |
| acc_cacheable | output | 1 | Access may allocate into the cache |
| acc_updateable | output | 1 | A write updates a matching cached line |
| acc_disruptive | output | 1 | Access lies in a disruptive region |

## Verification
The in-RTL assertions check these on every cycle:
- Each flush cause is followed by a pulse.
- No pulse occurs without a cause one cycle earlier.
- `acc_cacheable` never rises while the cache is off.
- The flags stay low while no access is valid.
- The upper control bits read as zero.

Only the bench scenarios can show the rest. These are the reset values, the per-region decode of each of the 32 map bits, next-cycle visibility of a map change, that flush-register data is ignored, and the single-pulse merge of simultaneous flush causes.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;

   typedef enum logic [2:0] {
      SEL_NONE0   = 3'd0,
      SEL_FLUSH   = 3'd1,
      SEL_CTRL    = 3'd2,
      SEL_CACHE   = 3'd3,
      SEL_UPDATE  = 3'd4,
      SEL_DISRUPT = 3'd5
   } reg_sel_e;

   typedef struct packed {
      logic cacheable;
      logic updateable;
      logic disruptive;
   } region_attr_t;

   localparam int MAP_COUNT = 3;

endpackage

// File: rtl/cc_regbank.sv
module cc_regbank
   import cache_ctl_pkg::*;
#(
   parameter int             DATA_W      = 32,
   parameter int             MAP_W       = 32,
   parameter logic [DATA_W-1:0] CACHE_RST   = 32'hFC00_7FFF,
   parameter logic [DATA_W-1:0] UPDATE_RST  = 32'h0000_7FFF,
   parameter logic [DATA_W-1:0] DISRUPT_RST = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        ctrl,
   output logic [MAP_W-1:0]  map_cache,
   output logic [MAP_W-1:0]  map_update,
   output logic [MAP_W-1:0]  map_disrupt,
   output logic              flush_req
);

   localparam int CTRL_W = 2;

   generate
      if (MAP_W > DATA_W) begin : g_bad_width
         $error("cc_regbank: MAP_W must not exceed DATA_W");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_q;
   logic [MAP_W-1:0]  map_q [MAP_COUNT];

   function automatic logic [MAP_W-1:0] rst_of(input int k);
      case (k)
         0:       return CACHE_RST[MAP_W-1:0];
         1:       return UPDATE_RST[MAP_W-1:0];
         default: return DISRUPT_RST[MAP_W-1:0];
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (we && sel == SEL_CTRL)
         ctrl_q <= wdata[CTRL_W-1:0];
   end

   generate
      for (genvar k = 0; k < MAP_COUNT; k++) begin : g_map
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               map_q[k] <= rst_of(k);
            else if (we && sel == 3'(int'(SEL_CACHE) + k))
               map_q[k] <= wdata[MAP_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_CTRL:    rdata = DATA_W'(ctrl_q);
         SEL_CACHE:   rdata = DATA_W'(map_q[0]);
         SEL_UPDATE:  rdata = DATA_W'(map_q[1]);
         SEL_DISRUPT: rdata = DATA_W'(map_q[2]);
         default:     rdata = '0;
      endcase
   end

   assign ctrl        = ctrl_q;
   assign map_cache   = map_q[0];
   assign map_update  = map_q[1];
   assign map_disrupt = map_q[2];
   assign flush_req   = we && (sel == SEL_FLUSH);

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTRL) |-> (rdata[DATA_W-1:CTRL_W] == '0)); // R9

   AST_FLUSH_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_FLUSH) |=> $stable(ctrl_q)); // R1

endmodule

// File: rtl/cc_region_decode.sv
module cc_region_decode
   import cache_ctl_pkg::*;
#(
   parameter int ADDR_W     = 26,
   parameter int REGION_LSB = 21
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   acc_valid,
   input  logic [ADDR_W-1:0]                      acc_addr,
   input  logic                                   cache_en,
   input  logic [(1 << (ADDR_W-REGION_LSB))-1:0]  map_cache,
   input  logic [(1 << (ADDR_W-REGION_LSB))-1:0]  map_update,
   input  logic [(1 << (ADDR_W-REGION_LSB))-1:0]  map_disrupt,
   output region_attr_t                           attr
);

   localparam int IDX_W = ADDR_W - REGION_LSB;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("cc_region_decode: region index width out of range");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             unused_offset;

   assign idx           = acc_addr[ADDR_W-1:REGION_LSB];
   assign unused_offset = ^acc_addr[REGION_LSB-1:0];

   always_comb begin
      attr.cacheable  = acc_valid && cache_en && map_cache[idx];
      attr.updateable = acc_valid && map_update[idx];
      attr.disruptive = acc_valid && map_disrupt[idx];
   end

   AST_IDLE_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (attr == '0)); // R12

   AST_OFF_NOT_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cache_en |-> !attr.cacheable); // R2

endmodule

// File: rtl/cc_flush_merge.sv
module cc_flush_merge #(
   parameter int N_SRC   = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   output logic             pulse
);

   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("cc_flush_merge: N_SRC must be at least 1");
      end
   endgenerate

   logic any_src;
   assign any_src = |src;

   generate
      if (REG_OUT) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= any_src;
         end
         assign pulse = pulse_q;

         AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            pulse |-> $past(any_src)); // R8
      end else begin : g_comb
         assign pulse = any_src;
      end
   endgenerate

endmodule

// File: rtl/cache_ctl_unit.sv
module cache_ctl_unit
   import cache_ctl_pkg::*;
#(
   parameter int               ADDR_W      = 26,
   parameter int               REGION_LSB  = 21,
   parameter int               DATA_W      = 32,
   parameter logic [DATA_W-1:0] CACHE_RST   = 32'hFC00_7FFF,
   parameter logic [DATA_W-1:0] UPDATE_RST  = 32'h0000_7FFF,
   parameter logic [DATA_W-1:0] DISRUPT_RST = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              cache_en,
   output logic              shared_xlat,
   output logic              flush_pulse,
   output logic              acc_cacheable,
   output logic              acc_updateable,
   output logic              acc_disruptive
);

   localparam int MAP_W = 1 << (ADDR_W - REGION_LSB);

   logic [1:0]       ctrl;
   logic [MAP_W-1:0] map_cache, map_update, map_disrupt;
   logic             sw_flush;
   region_attr_t     attr;
   logic [1:0]       flush_src;

   cc_regbank #(
      .DATA_W(DATA_W), .MAP_W(MAP_W),
      .CACHE_RST(CACHE_RST), .UPDATE_RST(UPDATE_RST), .DISRUPT_RST(DISRUPT_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .rdata(reg_rdata), .ctrl(ctrl), .map_cache(map_cache),
      .map_update(map_update), .map_disrupt(map_disrupt), .flush_req(sw_flush)
   );

   cc_region_decode #(.ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB)) u_decode (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .cache_en(ctrl[0]), .map_cache(map_cache), .map_update(map_update),
      .map_disrupt(map_disrupt), .attr(attr)
   );

   assign flush_src = {sw_flush, acc_write && attr.disruptive};

   cc_flush_merge #(.N_SRC(2), .REG_OUT(1'b1)) u_flush (
      .clk(clk), .rst_n(rst_n), .src(flush_src), .pulse(flush_pulse)
   );

   assign cache_en       = ctrl[0];
   assign shared_xlat    = ctrl[1];
   assign acc_cacheable  = attr.cacheable;
   assign acc_updateable = attr.updateable;
   assign acc_disruptive = attr.disruptive;

   AST_SW_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 3'd1) |=> flush_pulse); // R1

   AST_DISRUPT_WRITE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_disruptive) |=> flush_pulse); // R6

   AST_NO_SPURIOUS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past((reg_we && reg_sel == 3'd1) ||
                            (acc_valid && acc_write && acc_disruptive))); // R8

endmodule

// File: tb/cache_ctl_unit_tb.sv
`timescale 1ns/1ps
module cache_ctl_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [25:0] acc_addr = '0;
   logic        cache_en, shared_xlat, flush_pulse;
   logic        acc_cacheable, acc_updateable, acc_disruptive;

   int checks = 0, errors = 0;
   logic [1:0]  m_ctrl;
   logic [31:0] m_map [3];

   always #4 clk = ~clk;

   cache_ctl_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_write(acc_write), .acc_addr(acc_addr), .cache_en(cache_en),
      .shared_xlat(shared_xlat), .flush_pulse(flush_pulse),
      .acc_cacheable(acc_cacheable), .acc_updateable(acc_updateable),
      .acc_disruptive(acc_disruptive)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (sel == 3'd2) m_ctrl = d[1:0];
      if (sel >= 3'd3 && sel <= 3'd5) m_map[sel-3] = d;
   endtask

   function automatic logic [31:0] exp_read(input logic [2:0] sel);
      case (sel)
         3'd2: return {30'd0, m_ctrl};
         3'd3, 3'd4, 3'd5: return m_map[sel-3];
         default: return 32'd0;
      endcase
   endfunction

   task automatic read_all(input string req);
      for (int s = 0; s < 8; s++) begin
         reg_sel = s[2:0];
         #1;
         check(req, reg_rdata, exp_read(s[2:0]));
      end
   endtask

   // one access per region; checks flags and the flush that follows it
   task automatic sweep(input logic valid, input logic wr, input string req);
      for (int r = 0; r < 32; r++) begin
         logic [25:0] a;
         logic ef;
         a = {r[4:0], 21'((r * 37813) & 32'h1F_FFFF)};
         @(negedge clk);
         acc_valid = valid; acc_write = wr; acc_addr = a;
         #1;
         check({req, " R4 cacheable"}, 32'(acc_cacheable),
               32'(valid && m_ctrl[0] && m_map[0][r]));
         check({req, " R5 updateable"}, 32'(acc_updateable), 32'(valid && m_map[1][r]));
         check({req, " R6 disruptive"}, 32'(acc_disruptive), 32'(valid && m_map[2][r]));
         ef = valid && wr && m_map[2][r];
         @(negedge clk);
         acc_valid = 1'b0; acc_write = 1'b0;
         check({req, " R6 flush after access"}, 32'(flush_pulse), 32'(ef));
         @(negedge clk);
         check({req, " R6 flush one cycle"}, 32'(flush_pulse), 32'd0);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_ctrl = 2'b00;
      m_map[0] = 32'hFC00_7FFF;
      m_map[1] = 32'h0000_7FFF;
      m_map[2] = 32'hF000_0000;
      #1;
      check("R7 flush in reset", 32'(flush_pulse), 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 cache_en after reset", 32'(cache_en), 32'd0);
      check("R7 flush after reset", 32'(flush_pulse), 32'd0);
      read_all("R7 R11 reset readback");

      // cache off: no access cacheable; reads never flush
      sweep(1'b1, 1'b0, "R2 off read");
      sweep(1'b1, 1'b1, "R6 off write");
      sweep(1'b0, 1'b1, "R12 idle");

      // control register with all bits set
      reg_write(3'd2, 32'hFFFF_FFFF);
      check("R2 cache_en", 32'(cache_en), 32'd1);
      check("R3 shared_xlat", 32'(shared_xlat), 32'd1);
      reg_sel = 3'd2; #1;
      check("R9 ctrl upper zero", reg_rdata, 32'h0000_0003);
      sweep(1'b1, 1'b0, "R4 on defaults");

      reg_write(3'd2, 32'hFFFF_FFFD);
      check("R3 shared_xlat clear", 32'(shared_xlat), 32'd0);
      check("R2 cache_en stays", 32'(cache_en), 32'd1);

      // new map patterns, accesses start the cycle after the write
      begin
         logic [31:0] pats [4];
         pats[0] = 32'hA5A5_5A5A; pats[1] = 32'h0F0F_F0F0;
         pats[2] = 32'h8000_0001; pats[3] = 32'h7FFF_FFFE;
         for (int p = 0; p < 4; p++) begin
            reg_write(3'd3, pats[p]);
            reg_write(3'd4, ~pats[(p + 1) % 4]);
            reg_write(3'd5, pats[(p + 2) % 4]);
            read_all("R11 R10 readback");
            sweep(1'b1, 1'b1, "R10 pattern write");
            sweep(1'b1, 1'b0, "R10 pattern read");
         end
      end

      // flush register: data ignored, pulse one cycle
      reg_write(3'd1, 32'hFFFF_FFFF);
      check("R1 flush pulse", 32'(flush_pulse), 32'd1);
      @(negedge clk);
      check("R1 flush one cycle", 32'(flush_pulse), 32'd0);
      read_all("R1 registers unchanged");

      // merge: flush write with disruptive write access in one cycle
      reg_write(3'd5, 32'hFFFF_FFFF);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 3'd1; reg_wdata = 32'h0;
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 26'h3AB_CDEF;
      @(negedge clk);
      reg_we = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
      check("R8 merged pulse", 32'(flush_pulse), 32'd1);
      @(negedge clk);
      check("R8 single cycle", 32'(flush_pulse), 32'd0);

      // idle strobe into a disruptive region
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 26'h010_0000;
      #1;
      check("R12 idle flag", 32'(acc_disruptive), 32'd0);
      @(negedge clk);
      acc_write = 1'b0;
      check("R12 idle no flush", 32'(flush_pulse), 32'd0);

      // cache off again
      reg_write(3'd2, 32'h0000_0000);
      check("R2 cache_en off", 32'(cache_en), 32'd0);
      reg_write(3'd3, 32'hFFFF_FFFF);
      sweep(1'b1, 1'b0, "R2 off all cacheable map");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule